// File: doc/BRIEF.md
# SMBus Host Register Interface

This block is the software-visible register bank of an SMBus host controller. A processor reaches it through a byte-wide port with single-cycle read and write strobes. It keeps the transaction setup: command code, target address byte, two data bytes, a block data byte, the control byte and a two-bit auxiliary mode byte. It presents these setup values to a separate protocol sequencer and raises a one-cycle request when a transaction is to run. The sequencer reports back through done and error pulses, which set bits in the status byte.

Status bits are cleared by writing ones. Software cannot clear the busy flag. When the interrupt enable is off, a start does not launch anything. It only raises busy, and the launch happens on the next status read. That read still returns the busy value. Writing control with the kill bit aborts the operation: it sets the failed flag, drops busy and pulses a block-index clear to the buffer logic. A level interrupt output is driven whenever the interrupt enable is set and any status flag other than busy is set.

Top module: `smb_host_regs`

## Requirements
- R1: After reset the status byte, control byte, all setup bytes and `rdata` are zero, the auxiliary byte holds `2'b10` when `FORCE_BLK` is 1 and `2'b00` otherwise, and `irq`, `xact_req` and `idx_clr` are low.
- R2: Offsets decode as status 0x00, control 0x02, command 0x03, target address 0x04, data 0 0x05, data 1 0x06, block data 0x07 and auxiliary 0x0D. The command, target address, data and block data bytes read back what was last written. Every other offset reads as 0x00, and a write to it changes no readable byte.
- R3: A control write stores all bits except bit 6 (start). A control read returns only bits 4:0, with bits 7:5 reading as zero. Bit map: 0 interrupt enable, 1 kill, 4:2 protocol, 5 last byte, 6 start, 7 PEC enable.
- R4: The auxiliary byte keeps only bits 1:0 of a write (bit 0 PEC, bit 1 block-buffer mode), and its upper bits read as zero.
- R5: A write to status clears each of bits 7:1 written as 1 and leaves the others unchanged. Bit 0 (busy) is never changed by a status write. Status bit map: 0 busy, 1 done, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use, 7 byte done.
- R6: A control write with start (bit 6) and interrupt enable (bit 0) both set pulses `xact_req` high for exactly the one cycle after the write strobe, and leaves busy unchanged.
- R7: A control write with start set and interrupt enable clear sets busy and produces no `xact_req`.
- R8: A status read while busy is set returns the status with busy = 1. In the cycle after that read, busy is clear and `xact_req` is high for one cycle.
- R9: A control write with kill (bit 1) set sets failed (bit 4), clears busy and pulses `idx_clr` for the one cycle after the write. If start is also set, the kill result applies to busy.
- R10: `irq` is high exactly when control bit 0 is set and at least one of status bits 7:1 is set.
- R11: A `seq_done` pulse sets status bit 1, and a `seq_err` pulse sets status bit 2. Either one takes effect in the cycle after it, even when the same bit is being cleared by a status write in that cycle.
- R12: While device error (status bit 2) is set, neither an immediate start nor a deferred launch on a status read produces `xact_req`. The deferred launch still clears busy.
- R13: `rdata` is loaded at the clock edge that samples `rd_en`, which makes it valid from the cycle after the strobe. It holds its value on every cycle without a read. When `wr_en` and `rd_en` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | AW | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| seq_done | input | 1 | Sequencer completed a transaction |
| seq_err | input | 1 | Sequencer detected a device error |
| xact_req | output | 1 | One-cycle transaction launch request |
| idx_clr | output | 1 | One-cycle block index clear on kill |
| irq | output | 1 | Level interrupt |
| cfg_prot | output | 3 | Protocol select from control |
| cfg_last | output | 1 | Last-byte flag from control |
| cfg_pec | output | 1 | PEC enable from control |
| cfg_cmd | output | 8 | Command code |
| cfg_saddr | output | 8 | Target address byte, bit 0 direction |
| cfg_dat0 | output | 8 | Data byte 0 |
| cfg_dat1 | output | 8 | Data byte 1 |
| cfg_blk | output | 8 | Block data byte |
| cfg_aux | output | 2 | Auxiliary mode bits |

## Verification
Most state errors in this block show up at a port within one or two cycles. A stuck or wrongly cleared busy flag appears on the next status read and decides whether `xact_req` pulses in the following cycle. A status bit that is wrongly set raises `irq` in the same cycle whenever interrupts are enabled. A corrupted setup byte stays hidden until it is read back or used by the sequencer. For that reason the random phase keeps reading back every offset, and a write that has no effect is checked by a later read of the byte it could have changed.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
   localparam int DW   = 8;
   localparam int NREG = 8;

   localparam int IDX_STS = 0;
   localparam int IDX_CTL = 1;
   localparam int IDX_CMD = 2;
   localparam int IDX_SAD = 3;
   localparam int IDX_D0  = 4;
   localparam int IDX_D1  = 5;
   localparam int IDX_BLK = 6;
   localparam int IDX_AUX = 7;

   localparam int ST_BUSY = 0;
   localparam int ST_DONE = 1;
   localparam int ST_DEV  = 2;
   localparam int ST_FAIL = 4;

   localparam int CT_IE    = 0;
   localparam int CT_KILL  = 1;
   localparam int CT_LAST  = 5;
   localparam int CT_START = 6;
   localparam int CT_PEC   = 7;

   function automatic logic [7:0] slot_offset(input int i);
      case (i)
         IDX_STS: slot_offset = 8'h00;
         IDX_CTL: slot_offset = 8'h02;
         IDX_CMD: slot_offset = 8'h03;
         IDX_SAD: slot_offset = 8'h04;
         IDX_D0:  slot_offset = 8'h05;
         IDX_D1:  slot_offset = 8'h06;
         IDX_BLK: slot_offset = 8'h07;
         default: slot_offset = 8'h0D;
      endcase
   endfunction

   function automatic logic [7:0] slot_keep(input int i);
      case (i)
         IDX_CTL: slot_keep = 8'hBF;
         IDX_AUX: slot_keep = 8'h03;
         default: slot_keep = 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] slot_rdmask(input int i);
      slot_rdmask = (i == IDX_CTL) ? 8'h1F : 8'hFF;
   endfunction
endpackage

// File: rtl/smb_addr_dec.sv
module smb_addr_dec
   import smb_regs_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic [AW-1:0]   addr,
   output logic [NREG-1:0] sel
);
   for (genvar i = 0; i < NREG; i++) begin : g_sel
      localparam logic [7:0] OFF = slot_offset(i);
      assign sel[i] = (addr == AW'(OFF));
   end
endmodule

// File: rtl/smb_byte_reg.sv
module smb_byte_reg #(
   parameter logic [7:0] RST  = 8'h00,
   parameter logic [7:0] KEEP = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] d,
   output logic [7:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d & KEEP;
   end
endmodule

// File: rtl/smb_status_reg.sv
module smb_status_reg
   import smb_regs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wd,
   input  logic       defer_set,
   input  logic       poll_clr,
   input  logic       kill,
   input  logic       seq_done,
   input  logic       seq_err,
   output logic [7:0] sts
);
   logic [7:0] nxt;

   always_comb begin
      nxt = sts;
      if (wr)        nxt = nxt & ~{wd[7:1], 1'b0};
      if (defer_set) nxt[ST_BUSY] = 1'b1;
      if (poll_clr)  nxt[ST_BUSY] = 1'b0;
      if (kill) begin
         nxt[ST_FAIL] = 1'b1;
         nxt[ST_BUSY] = 1'b0;
      end
      if (seq_done)  nxt[ST_DONE] = 1'b1;
      if (seq_err)   nxt[ST_DEV]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sts <= '0;
      else        sts <= nxt;
   end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
   import smb_regs_pkg::*;
#(
   parameter int AW        = 4,
   parameter bit FORCE_BLK = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic          seq_done,
   input  logic          seq_err,
   output logic          xact_req,
   output logic          idx_clr,
   output logic          irq,
   output logic [2:0]    cfg_prot,
   output logic          cfg_last,
   output logic          cfg_pec,
   output logic [7:0]    cfg_cmd,
   output logic [7:0]    cfg_saddr,
   output logic [7:0]    cfg_dat0,
   output logic [7:0]    cfg_dat1,
   output logic [7:0]    cfg_blk,
   output logic [1:0]    cfg_aux
);
   localparam logic [7:0] AUX_RST = FORCE_BLK ? 8'h02 : 8'h00;

   if (AW < 4) begin : g_aw_chk
      $error("smb_host_regs: AW must be at least 4");
   end

   logic [NREG-1:0]         sel;
   logic [NREG-1:0][DW-1:0] slot_q;
   logic [7:0]              sts_q;
   logic [7:0]              ctl_q;
   logic                    rd_act, wr_ctl, start_w, kill_w, poll, launch;
   logic [7:0]              rd_mux;
   logic                    req_q, idx_q;
   logic [7:0]              rdata_q;

   smb_addr_dec #(.AW(AW)) u_dec (.addr(addr), .sel(sel));

   assign rd_act  = rd_en & ~wr_en;
   assign wr_ctl  = wr_en & sel[IDX_CTL];
   assign start_w = wr_ctl & wdata[CT_START];
   assign kill_w  = wr_ctl & wdata[CT_KILL];
   assign poll    = rd_act & sel[IDX_STS] & sts_q[ST_BUSY];
   assign launch  = (start_w & wdata[CT_IE]) | poll;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (i == IDX_STS) begin : g_sts
         smb_status_reg u_sts (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_en & sel[i]),
            .wd        (wdata),
            .defer_set (start_w & ~wdata[CT_IE]),
            .poll_clr  (poll),
            .kill      (kill_w),
            .seq_done  (seq_done),
            .seq_err   (seq_err),
            .sts       (slot_q[i])
         );
      end else begin : g_byte
         smb_byte_reg #(
            .RST  ((i == IDX_AUX) ? AUX_RST : 8'h00),
            .KEEP (slot_keep(i))
         ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & sel[i]),
            .d     (wdata),
            .q     (slot_q[i])
         );
      end
   end

   assign sts_q = slot_q[IDX_STS];
   assign ctl_q = slot_q[IDX_CTL];

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) rd_mux = rd_mux | (slot_q[i] & slot_rdmask(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         idx_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         req_q <= launch & ~sts_q[ST_DEV];
         idx_q <= kill_w;
         if (rd_act) rdata_q <= rd_mux;
      end
   end

   assign rdata     = rdata_q;
   assign xact_req  = req_q;
   assign idx_clr   = idx_q;
   assign irq       = ctl_q[CT_IE] & (|sts_q[7:1]);
   assign cfg_prot  = ctl_q[4:2];
   assign cfg_last  = ctl_q[CT_LAST];
   assign cfg_pec   = ctl_q[CT_PEC];
   assign cfg_cmd   = slot_q[IDX_CMD];
   assign cfg_saddr = slot_q[IDX_SAD];
   assign cfg_dat0  = slot_q[IDX_D0];
   assign cfg_dat1  = slot_q[IDX_D1];
   assign cfg_blk   = slot_q[IDX_BLK];
   assign cfg_aux   = slot_q[IDX_AUX][1:0];
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
   import smb_regs_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic [AW-1:0] addr,
   input logic [7:0]    wdata,
   input logic          seq_done,
   input logic          xact_req,
   input logic          idx_clr,
   input logic          irq,
   input logic [7:0]    sts,
   input logic          ie
);
   logic at_sts, at_ctl;
   assign at_sts = (addr == AW'(8'h00));
   assign at_ctl = (addr == AW'(8'h02));

   a_r7_defer_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_ctl && wdata[CT_START] && !wdata[CT_IE] && !wdata[CT_KILL])
      |=> (sts[ST_BUSY] && !xact_req));

   a_r6_immediate_req: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_ctl && wdata[CT_START] && wdata[CT_IE] && !sts[ST_DEV])
      |=> xact_req);

   a_r12_deverr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_ctl && wdata[CT_START] && wdata[CT_IE] && sts[ST_DEV])
      |=> !xact_req);

   a_r8_poll_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && at_sts && sts[ST_BUSY])
      |=> (!sts[ST_BUSY] && (xact_req == !$past(sts[ST_DEV]))));

   a_r9_kill: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_ctl && wdata[CT_KILL])
      |=> (sts[ST_FAIL] && !sts[ST_BUSY] && idx_clr));

   a_r5_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_sts) |=> (sts[ST_BUSY] == $past(sts[ST_BUSY])));

   a_r10_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[7:1] == 7'd0 || !ie) |-> !irq);

   a_r11_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> sts[ST_DONE]);
endmodule

bind smb_host_regs smb_host_regs_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .seq_done (seq_done),
   .xact_req (xact_req),
   .idx_clr  (idx_clr),
   .irq      (irq),
   .sts      (sts_q),
   .ie       (ctl_q[0])
);

// File: tb/sim_smb_host_regs.sv
module sim_smb_host_regs;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, seq_done = 1'b0, seq_err = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          xact_req, idx_clr, irq, cfg_last, cfg_pec;
   logic [2:0]    cfg_prot;
   logic [7:0]    cfg_cmd, cfg_saddr, cfg_dat0, cfg_dat1, cfg_blk;
   logic [1:0]    cfg_aux;

   int total = 0, bad = 0, cycles = 0;
   logic [7:0] m_sts = 0, m_ctl = 0, m_aux = 0, m_rd = 0;
   logic [7:0] m_plain [16];

   always #10 clk = ~clk;

   smb_host_regs #(.AW(AW), .FORCE_BLK(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .seq_done(seq_done), .seq_err(seq_err),
      .xact_req(xact_req), .idx_clr(idx_clr), .irq(irq), .cfg_prot(cfg_prot),
      .cfg_last(cfg_last), .cfg_pec(cfg_pec), .cfg_cmd(cfg_cmd),
      .cfg_saddr(cfg_saddr), .cfg_dat0(cfg_dat0), .cfg_dat1(cfg_dat1),
      .cfg_blk(cfg_blk), .cfg_aux(cfg_aux)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input int a);
      case (a)
         0:       exp_read = m_sts;
         2:       exp_read = m_ctl & 8'h1F;
         3, 4, 5, 6, 7: exp_read = m_plain[a];
         13:      exp_read = m_aux;
         default: exp_read = 8'h00;
      endcase
   endfunction

   function automatic bit exp_irq();
      exp_irq = m_ctl[0] && (m_sts[7:1] != 0);
   endfunction

   // One bus cycle; entered and left at a falling edge.
   task automatic cyc(input bit w, input bit r, input int a, input logic [7:0] d,
                      input bit sd, input bit se, input string tag);
      bit e_req = 0, e_idx = 0;
      bit old_dev = m_sts[2];
      if (w) begin
         case (a)
            0: m_sts = m_sts & ~{d[7:1], 1'b0};
            2: begin
               m_ctl = d & 8'hBF;
               if (d[6] && d[0]) e_req = !old_dev;
               if (d[6] && !d[0]) m_sts[0] = 1'b1;
               if (d[1]) begin m_sts[4] = 1'b1; m_sts[0] = 1'b0; e_idx = 1; end
            end
            3, 4, 5, 6, 7: m_plain[a] = d;
            13: m_aux = d & 8'h03;
            default: ;
         endcase
      end else if (r) begin
         m_rd = exp_read(a);
         if (a == 0 && m_sts[0]) begin m_sts[0] = 1'b0; e_req = !old_dev; end
      end
      if (sd) m_sts[1] = 1'b1;
      if (se) m_sts[2] = 1'b1;
      wr_en = w; rd_en = r; addr = AW'(a); wdata = d; seq_done = sd; seq_err = se;
      @(negedge clk);
      wr_en = 0; rd_en = 0; seq_done = 0; seq_err = 0;
      chk(rdata == m_rd, {tag, " rdata (R13)"}, rdata, m_rd);
      chk(xact_req == e_req, {tag, " xact_req (R6)"}, {7'd0, xact_req}, {7'd0, e_req});
      chk(idx_clr == e_idx, {tag, " idx_clr (R9)"}, {7'd0, idx_clr}, {7'd0, e_idx});
      chk(irq == exp_irq(), {tag, " irq (R10)"}, {7'd0, irq}, {7'd0, exp_irq()});
   endtask

   task automatic wr(input int a, input logic [7:0] d, input string tag);
      cyc(1, 0, a, d, 0, 0, tag);
   endtask
   task automatic rd(input int a, input string tag);
      cyc(0, 1, a, 8'h00, 0, 0, tag);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) m_plain[i] = 8'h00;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(rdata == 0, "R1 rdata after reset", rdata, 8'h00);
      chk(!irq && !xact_req && !idx_clr, "R1 outputs after reset",
          {5'd0, irq, xact_req, idx_clr}, 8'h00);
      rd(0, "R1 status");    rd(2, "R1 control");  rd(13, "R1 aux");
      rd(5, "R1 data0");
      // R2 offsets and undecoded holes
      wr(3, 8'hA1, "R2"); wr(4, 8'hB2, "R2"); wr(5, 8'hC3, "R2");
      wr(6, 8'hD4, "R2"); wr(7, 8'hE5, "R2");
      wr(1, 8'h55, "R2 hole"); wr(8, 8'h66, "R2 hole"); wr(15, 8'h77, "R2 hole");
      for (int a = 0; a < 16; a++) rd(a, "R2 readback");
      // R3 control mask, R4 aux mask
      wr(2, 8'hA4, "R3"); rd(2, "R3");
      chk(cfg_prot == 3'd1 && cfg_pec, "R3 cfg fields", {4'd0, cfg_pec, cfg_prot}, 8'h09);
      wr(13, 8'hFF, "R4"); rd(13, "R4");
      // R7 deferral then R8 launch on poll
      wr(2, 8'h40, "R7"); rd(0, "R8 poll busy"); rd(0, "R8 poll again");
      // R6 immediate
      wr(2, 8'h41, "R6"); rd(0, "R6 no busy");
      // R11 sequencer pulses, R10 irq, R5 clear
      cyc(0, 0, 0, 8'h00, 1, 0, "R11 done"); rd(0, "R11");
      wr(0, 8'h02, "R5 clear done");
      cyc(1, 0, 0, 8'h02, 1, 0, "R11 set beats clear"); rd(0, "R11");
      wr(2, 8'h40, "R7 busy"); wr(0, 8'hFF, "R5 busy kept"); rd(2, "R5 idle"); rd(0, "R5");
      // R12 device error blocks launch
      cyc(0, 0, 0, 8'h00, 0, 1, "R12 err"); wr(2, 8'h41, "R12 immediate");
      wr(2, 8'h40, "R12 deferred"); rd(0, "R12 poll"); rd(0, "R12 after");
      // R9 kill, with and without start
      wr(2, 8'h40, "R9 arm"); wr(2, 8'h02, "R9 kill"); rd(0, "R9");
      wr(2, 8'h42, "R9 start+kill"); rd(0, "R9");
      wr(0, 8'hFE, "R5 clear all"); rd(0, "R5");
      // R13 read-data hold and write priority
      rd(3, "R13"); cyc(0, 0, 0, 0, 0, 0, "R13 hold");
      cyc(1, 1, 4, 8'h3C, 0, 0, "R13 write wins"); rd(4, "R13");
      // random mix
      for (int n = 0; n < 4000; n++) begin
         int k = $urandom % 10;
         int a = $urandom % 16;
         logic [7:0] d = 8'($urandom);
         bit sd = ($urandom % 10) == 0;
         bit se = ($urandom % 25) == 0;
         if (k < 4)      cyc(1, 0, a, d, sd, se, "R2 random write");
         else if (k < 8) cyc(0, 1, a, 8'h00, sd, se, "R2 random read");
         else            cyc(0, 0, 0, 8'h00, sd, se, "R11 random idle");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule